// File: doc/BRIEF.md
# Two-Queue Conversion Arbiter

This block decides which of two lists of conversion commands may use a single shared converter. Each list (queue) lives in one command table. An entry carries two flag bits: a hold flag that ends a subqueue, and a last flag that ends the whole queue. The high-priority queue begins at table index 0. The low-priority queue begins at index `LO_BASE`. The block issues one conversion at a time. It puts the index of the entry on `cmd_idx` and pulses `conv_start`. When the converter pulses `conv_done`, the block reads the two flag bits of that entry from the table through the same index.

The high-priority queue always wins. A trigger for it while the low-priority queue is running cancels the low queue's in-flight conversion through `conv_abort` and sets the low queue aside. A trigger for the low queue while the high queue runs is held as pending. The low queue runs as soon as the high queue holds or finishes. A trigger that cannot be honoured raises a sticky overrun flag, so no trigger disappears without trace. When the low queue comes back after being set aside, `resume_sub` chooses where it restarts: at the start of the queue, or at the start of the subqueue it was in.

Top module: `dualq_sched`

## Requirements
- R1: During and after a synchronous reset (`rst` high), both statuses read 0 (idle), both overrun flags and both completion pulses are 0, `conv_start` and `conv_abort` are 0, and `cmd_idx` is 0.
- R2: A trigger to a queue whose status is idle (0), held (2) or finished (5) makes that queue running (1) when the other queue is not running. On the edge that samples the trigger, `conv_start` is raised with `cmd_idx` at the queue's current entry: 0 (high) or `LO_BASE` (low) after reset or after finishing.
- R3: A low trigger that arrives while the high queue is running, or in the same cycle as a high trigger, sets the low status to pending (3). The two queues are never running together. A pending or set-aside low queue becomes running on the edge where the high queue holds or finishes.
- R4: A high trigger while the low queue is running sets the low status to set-aside (4) and makes the high queue running. If a low conversion is in flight and not finishing in that cycle, `conv_abort` pulses for one cycle and a high conversion starts on that edge.
- R5: When set aside, the low queue restarts at `LO_BASE` if `resume_sub` is 0 when the high trigger is sampled. If it is 1, the low queue restarts at the first entry of the subqueue it was in.
- R6: When a conversion finishes on an entry whose hold flag is 1 (and last flag 0), the queue goes to held (2) and starts nothing more until its next trigger. That trigger continues at the following entry.
- R7: When a conversion finishes on an entry whose last flag is 1, the queue's status goes to finished (5). Its `cmpl_pulse` bit (bit 0 high, bit 1 low) is 1 for exactly one cycle, and its next run starts at its base index.
- R8: A trigger to a queue that is running, pending or set aside sets that queue's `ovr_flag` bit (bit 0 high, bit 1 low). The bit stays set until a cycle with the matching `ovr_clr` bit high and no new overrun; if both happen in the same cycle, the set wins.
- R9: When a low conversion finishes in the same cycle as a high trigger, the finished entry is retired first (advance, hold or finish), and no `conv_abort` is issued.
- R10: At most one conversion is outstanding. After `conv_done`, the next entry of a running queue starts on the same edge that retires the finished one. `conv_done` is taken into account only while a conversion is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_hi | input | 1 | Trigger pulse, high-priority queue |
| trig_lo | input | 1 | Trigger pulse, low-priority queue |
| resume_sub | input | 1 | Restart point of the low queue after being set aside (0 base, 1 subqueue start) |
| ovr_clr | input | 2 | Write-one-to-clear pulses for the overrun flags |
| conv_done | input | 1 | Converter finished the outstanding conversion |
| cmd_hold | input | 1 | Hold flag of the table entry at `cmd_idx` |
| cmd_last | input | 1 | Last flag of the table entry at `cmd_idx` |
| cmd_idx | output | IDX_W | Table index of the outstanding or starting conversion |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_abort | output | 1 | One-cycle cancel strobe to the converter |
| hi_status | output | 3 | High queue status: 0 idle, 1 running, 2 held, 3 pending, 4 set aside, 5 finished |
| lo_status | output | 3 | Low queue status, same coding |
| ovr_flag | output | 2 | Sticky overrun flags |
| cmpl_pulse | output | 2 | One-cycle queue-finished pulses |

## Verification
Two events can land in the same cycle: a low-queue conversion finishing and a high-queue trigger. Both triggers can also arrive together. The bench watches its converter model's countdown and fires the high trigger in the very cycle the last low entry reports done. It then expects a finished low status, a low completion pulse and no cancel strobe. Separately, both triggers are raised together from idle, and the low queue is expected to go pending. The random phase keeps mixing these collisions with overrun-flag clears, and a cycle-level bench model judges every cycle.

// File: rtl/qsched_pkg.sv
package qsched_pkg;

    typedef enum logic [2:0] {
        QS_IDLE    = 3'd0,
        QS_RUN     = 3'd1,
        QS_HOLD    = 3'd2,
        QS_WAIT    = 3'd3,
        QS_ASIDE   = 3'd4,
        QS_DONE    = 3'd5
    } qstat_e;

    localparam int NQ = 2;

endpackage

// File: rtl/qsched_ovr.sv
module qsched_ovr #(
    parameter int NQ = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NQ-1:0] set_i,
    input  logic [NQ-1:0] clr_i,
    output logic [NQ-1:0] flag_o
);

    logic [NQ-1:0] flag_d, flag_q;

    for (genvar g = 0; g < NQ; g++) begin : g_bit
        always_comb begin
            flag_d[g] = set_i[g] | (flag_q[g] & ~clr_i[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/qsched_ptr.sv
module qsched_ptr #(
    parameter int IDX_W = 4,
    parameter int BASE  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    input  logic             hold_i,
    input  logic             last_i,
    input  logic             rewind_i,
    input  logic             resume_sub,
    output logic [IDX_W-1:0] ptr_nxt,
    output logic [IDX_W-1:0] ptr_cur
);

    localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(BASE);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
        logic [IDX_W-1:0] sub;
    } pstate_t;

    pstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (last_i) begin
            st_d.ptr = BASE_IDX;
            st_d.sub = BASE_IDX;
        end else if (hold_i) begin
            st_d.ptr = st_q.ptr + 1'b1;
            st_d.sub = st_q.ptr + 1'b1;
        end else if (adv_i) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
        if (rewind_i) begin
            if (resume_sub) begin
                st_d.ptr = st_d.sub;
            end else begin
                st_d.ptr = BASE_IDX;
                st_d.sub = BASE_IDX;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ptr <= BASE_IDX;
            st_q.sub <= BASE_IDX;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_nxt = st_d.ptr;
    assign ptr_cur = st_q.ptr;

endmodule

// File: rtl/dualq_sched.sv
module dualq_sched
    import qsched_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int LO_BASE = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_hi,
    input  logic             trig_lo,
    input  logic             resume_sub,
    input  logic [1:0]       ovr_clr,
    input  logic             conv_done,
    input  logic             cmd_hold,
    input  logic             cmd_last,
    output logic [IDX_W-1:0] cmd_idx,
    output logic             conv_start,
    output logic             conv_abort,
    output logic [2:0]       hi_status,
    output logic [2:0]       lo_status,
    output logic [1:0]       ovr_flag,
    output logic [1:0]       cmpl_pulse
);

    typedef struct packed {
        qstat_e           st_hi;
        qstat_e           st_lo;
        logic             busy;
        logic             own_lo;
        logic             start;
        logic             abort;
        logic [IDX_W-1:0] idx;
        logic [1:0]       cmpl;
    } core_t;

    core_t r_d, r_q;

    logic [NQ-1:0]    ev_adv, ev_hold, ev_last, ev_rew, ovr_set;
    logic [IDX_W-1:0] ptr_nxt [NQ];
    logic [IDX_W-1:0] ptr_cur [NQ];
    logic             retire;

    // one pointer unit per queue; base index chosen by generate index
    for (genvar g = 0; g < NQ; g++) begin : g_q
        qsched_ptr #(
            .IDX_W (IDX_W),
            .BASE  ((g == 0) ? 0 : LO_BASE)
        ) u_ptr (
            .clk        (clk),
            .rst        (rst),
            .adv_i      (ev_adv[g]),
            .hold_i     (ev_hold[g]),
            .last_i     (ev_last[g]),
            .rewind_i   (ev_rew[g]),
            .resume_sub (resume_sub),
            .ptr_nxt    (ptr_nxt[g]),
            .ptr_cur    (ptr_cur[g])
        );
    end

    qsched_ovr #(.NQ(NQ)) u_ovr (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ovr_set),
        .clr_i  (ovr_clr),
        .flag_o (ovr_flag)
    );

    always_comb begin
        r_d        = r_q;
        r_d.start  = 1'b0;
        r_d.abort  = 1'b0;
        r_d.cmpl   = 2'b00;
        ev_adv     = '0;
        ev_hold    = '0;
        ev_last    = '0;
        ev_rew     = '0;
        ovr_set    = '0;
        retire     = conv_done & r_q.busy;

        // 1) retire the finished conversion
        if (retire) begin
            r_d.busy = 1'b0;
            if (cmd_last) begin
                ev_last[r_q.own_lo] = 1'b1;
                r_d.cmpl[r_q.own_lo] = 1'b1;
                if (r_q.own_lo) r_d.st_lo = QS_DONE;
                else            r_d.st_hi = QS_DONE;
            end else if (cmd_hold) begin
                ev_hold[r_q.own_lo] = 1'b1;
                if (r_q.own_lo) r_d.st_lo = QS_HOLD;
                else            r_d.st_hi = QS_HOLD;
            end else begin
                ev_adv[r_q.own_lo] = 1'b1;
            end
        end

        // 2) high-priority trigger, with preemption of the low queue
        if (trig_hi) begin
            if (r_d.st_hi == QS_RUN) begin
                ovr_set[0] = 1'b1;
            end else begin
                r_d.st_hi = QS_RUN;
                if (r_d.st_lo == QS_RUN) begin
                    r_d.st_lo = QS_ASIDE;
                    ev_rew[1] = 1'b1;
                    if (r_d.busy && r_d.own_lo) begin
                        r_d.abort = 1'b1;
                        r_d.busy  = 1'b0;
                    end
                end
            end
        end

        // 3) low-priority trigger
        if (trig_lo) begin
            if (r_d.st_lo inside {QS_RUN, QS_WAIT, QS_ASIDE}) begin
                ovr_set[1] = 1'b1;
            end else if (r_d.st_hi == QS_RUN) begin
                r_d.st_lo = QS_WAIT;
            end else begin
                r_d.st_lo = QS_RUN;
            end
        end

        // 4) hand the converter back to a waiting low queue
        if ((r_d.st_hi != QS_RUN) && (r_d.st_lo inside {QS_WAIT, QS_ASIDE})) begin
            r_d.st_lo = QS_RUN;
        end

        // 5) issue the next conversion, high queue first
        if (!r_d.busy) begin
            if (r_d.st_hi == QS_RUN) begin
                r_d.start  = 1'b1;
                r_d.busy   = 1'b1;
                r_d.own_lo = 1'b0;
                r_d.idx    = ptr_nxt[0];
            end else if (r_d.st_lo == QS_RUN) begin
                r_d.start  = 1'b1;
                r_d.busy   = 1'b1;
                r_d.own_lo = 1'b1;
                r_d.idx    = ptr_nxt[1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st_hi  <= QS_IDLE;
            r_q.st_lo  <= QS_IDLE;
            r_q.busy   <= 1'b0;
            r_q.own_lo <= 1'b0;
            r_q.start  <= 1'b0;
            r_q.abort  <= 1'b0;
            r_q.idx    <= '0;
            r_q.cmpl   <= 2'b00;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_idx    = r_q.idx;
    assign conv_start = r_q.start;
    assign conv_abort = r_q.abort;
    assign hi_status  = r_q.st_hi;
    assign lo_status  = r_q.st_lo;
    assign cmpl_pulse = r_q.cmpl;

endmodule

// File: rtl/qsched_chk.sv
module qsched_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             trig_hi,
    input logic             trig_lo,
    input logic [1:0]       ovr_clr,
    input logic [IDX_W-1:0] cmd_idx,
    input logic             conv_start,
    input logic             conv_abort,
    input logic [2:0]       hi_status,
    input logic [2:0]       lo_status,
    input logic [1:0]       ovr_flag,
    input logic [1:0]       cmpl_pulse
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (hi_status == 3'd0 && lo_status == 3'd0 && !conv_start && !conv_abort && ovr_flag == 2'b00));

    assert_single_run_R3: assert property (@(posedge clk) disable iff (rst)
        !(hi_status == 3'd1 && lo_status == 3'd1));

    assert_joint_trig_R3: assert property (@(posedge clk) disable iff (rst)
        (trig_hi && trig_lo && (lo_status inside {3'd0, 3'd2, 3'd5})) |=> (lo_status == 3'd3));

    assert_abort_aside_R4: assert property (@(posedge clk) disable iff (rst)
        conv_abort |-> (lo_status == 3'd4 && hi_status == 3'd1 && conv_start));

    assert_held_stays_R6: assert property (@(posedge clk) disable iff (rst)
        (hi_status == 3'd2 && !trig_hi) |=> (hi_status == 3'd2));

    assert_cmpl_hi_R7: assert property (@(posedge clk) disable iff (rst)
        cmpl_pulse[0] |-> ($past(hi_status) == 3'd1));

    assert_cmpl_lo_R7: assert property (@(posedge clk) disable iff (rst)
        cmpl_pulse[1] |-> ($past(lo_status) == 3'd1));

    assert_ovr_hi_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag[0] && !ovr_clr[0]) |=> ovr_flag[0]);

    assert_ovr_lo_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag[1] && !ovr_clr[1]) |=> ovr_flag[1]);

    assert_start_owner_R10: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (hi_status == 3'd1 || lo_status == 3'd1));

    assert_idx_steady_R10: assert property (@(posedge clk) disable iff (rst)
        !conv_start |-> $stable(cmd_idx));

endmodule

bind dualq_sched qsched_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .trig_hi    (trig_hi),
    .trig_lo    (trig_lo),
    .ovr_clr    (ovr_clr),
    .cmd_idx    (cmd_idx),
    .conv_start (conv_start),
    .conv_abort (conv_abort),
    .hi_status  (hi_status),
    .lo_status  (lo_status),
    .ovr_flag   (ovr_flag),
    .cmpl_pulse (cmpl_pulse)
);

// File: tb/dualq_sched_test.sv
module dualq_sched_test;

    localparam int IDX_W   = 4;
    localparam int DEPTH   = 16;
    localparam int LO_BASE = 8;
    localparam int LAT     = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig_hi = 1'b0, trig_lo = 1'b0, resume_sub = 1'b0;
    logic [1:0]       ovr_clr = 2'b00;
    logic             conv_done = 1'b0;
    logic             cmd_hold, cmd_last;
    logic [IDX_W-1:0] cmd_idx;
    logic             conv_start, conv_abort;
    logic [2:0]       hi_status, lo_status;
    logic [1:0]       ovr_flag, cmpl_pulse;

    logic [DEPTH-1:0] tb_hold, tb_last;

    assign cmd_hold = tb_hold[cmd_idx];
    assign cmd_last = tb_last[cmd_idx];

    always #2 clk = ~clk;

    dualq_sched #(.IDX_W(IDX_W), .LO_BASE(LO_BASE)) uut (
        .clk(clk), .rst(rst), .trig_hi(trig_hi), .trig_lo(trig_lo),
        .resume_sub(resume_sub), .ovr_clr(ovr_clr), .conv_done(conv_done),
        .cmd_hold(cmd_hold), .cmd_last(cmd_last), .cmd_idx(cmd_idx),
        .conv_start(conv_start), .conv_abort(conv_abort),
        .hi_status(hi_status), .lo_status(lo_status),
        .ovr_flag(ovr_flag), .cmpl_pulse(cmpl_pulse)
    );

    int n_chk = 0;
    int n_err = 0;
    int cnt   = 0;

    // bench reference state
    int       m_st [2];
    int       m_p  [2];
    int       m_s  [2];
    bit       m_busy, m_own, m_start, m_abort;
    int       m_idx;
    bit [1:0] m_cmpl, m_ovr;

    function automatic int base_of(int q);
        return (q == 0) ? 0 : LO_BASE;
    endfunction

    function automatic void chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endfunction

    function automatic void model_reset();
        for (int q = 0; q < 2; q++) begin
            m_st[q] = 0; m_p[q] = base_of(q); m_s[q] = base_of(q);
        end
        m_busy = 0; m_own = 0; m_start = 0; m_abort = 0;
        m_idx = 0; m_cmpl = 0; m_ovr = 0;
    endfunction

    function automatic void model_update(bit t1, bit t2, bit res, bit [1:0] clr, bit dn);
        bit [1:0] oset = 2'b00;
        int o;
        m_start = 0; m_abort = 0; m_cmpl = 0;
        if (dn && m_busy) begin
            o = m_own ? 1 : 0;
            m_busy = 0;
            if (tb_last[m_idx]) begin
                m_st[o] = 5; m_cmpl[o] = 1'b1; m_p[o] = base_of(o); m_s[o] = base_of(o);
            end else if (tb_hold[m_idx]) begin
                m_st[o] = 2; m_p[o] = (m_p[o] + 1) % DEPTH; m_s[o] = m_p[o];
            end else begin
                m_p[o] = (m_p[o] + 1) % DEPTH;
            end
        end
        if (t1) begin
            if (m_st[0] == 1) oset[0] = 1'b1;
            else begin
                m_st[0] = 1;
                if (m_st[1] == 1) begin
                    m_st[1] = 4;
                    if (res) m_p[1] = m_s[1];
                    else begin m_p[1] = LO_BASE; m_s[1] = LO_BASE; end
                    if (m_busy && m_own) begin m_abort = 1; m_busy = 0; end
                end
            end
        end
        if (t2) begin
            if (m_st[1] == 1 || m_st[1] == 3 || m_st[1] == 4) oset[1] = 1'b1;
            else if (m_st[0] == 1) m_st[1] = 3;
            else m_st[1] = 1;
        end
        if (m_st[0] != 1 && (m_st[1] == 3 || m_st[1] == 4)) m_st[1] = 1;
        m_ovr = oset | (m_ovr & ~clr);
        if (!m_busy) begin
            if (m_st[0] == 1) begin
                m_start = 1; m_busy = 1; m_own = 0; m_idx = m_p[0];
            end else if (m_st[1] == 1) begin
                m_start = 1; m_busy = 1; m_own = 1; m_idx = m_p[1];
            end
        end
    endfunction

    task automatic compare_all();
        chk("R3 hi_status", int'(hi_status), m_st[0]);
        chk("R3 lo_status", int'(lo_status), m_st[1]);
        chk("R10 conv_start", int'(conv_start), int'(m_start));
        chk("R4 conv_abort", int'(conv_abort), int'(m_abort));
        chk("R2 cmd_idx", int'(cmd_idx), m_idx);
        chk("R8 ovr_flag", int'(ovr_flag), int'(m_ovr));
        chk("R7 cmpl_pulse", int'(cmpl_pulse), int'(m_cmpl));
    endtask

    task automatic step(input bit t1, input bit t2, input bit res, input bit [1:0] clr);
        bit dn;
        int cnx;
        @(negedge clk);
        trig_hi = t1; trig_lo = t2; resume_sub = res; ovr_clr = clr;
        dn = (cnt == 1) && !conv_abort;
        conv_done = dn;
        cnx = conv_start ? LAT : (conv_abort ? 0 : ((cnt > 0) ? cnt - 1 : 0));
        model_update(t1, t2, res, clr, dn);
        @(posedge clk);
        #1;
        cnt = cnx;
        compare_all();
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; trig_hi = 0; trig_lo = 0; ovr_clr = 0; conv_done = 0; resume_sub = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        cnt = 0;
    endtask

    task automatic wait_hi(input int s);
        for (int i = 0; i < 60 && int'(hi_status) != s; i++) idle();
    endtask

    task automatic wait_lo(input int s);
        for (int i = 0; i < 60 && int'(lo_status) != s; i++) idle();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        // high queue: 0 plain, 1 hold, 2 plain, 3 last; low: 8 plain, 9 hold, 10-11 plain, 12 last
        tb_hold = 16'h0202;
        tb_last = 16'h1008;
        model_reset();
        #1;
        @(posedge clk); #1;
        chk("R1 hi_status in reset", int'(hi_status), 0);
        chk("R1 lo_status in reset", int'(lo_status), 0);
        chk("R1 conv_start in reset", int'(conv_start), 0);
        do_reset();
        chk("R1 ovr_flag after reset", int'(ovr_flag), 0);
        chk("R1 cmd_idx after reset", int'(cmd_idx), 0);

        // low queue starts, then high trigger cancels the in-flight entry
        step(0, 1, 0, 2'b00);
        chk("R2 lo running", int'(lo_status), 1);
        chk("R2 start lo base", int'(cmd_idx), LO_BASE);
        idle();
        step(1, 0, 0, 2'b00);
        chk("R4 lo set aside", int'(lo_status), 4);
        chk("R4 abort strobe", int'(conv_abort), 1);
        chk("R4 hi start idx", int'(cmd_idx), 0);

        // high queue holds after entry 1; low restarts at its base
        wait_hi(2);
        chk("R6 hi held", int'(hi_status), 2);
        chk("R5 lo resumed running", int'(lo_status), 1);
        chk("R5 lo restart at base", int'(cmd_idx), LO_BASE);

        wait_lo(2);
        chk("R6 lo held", int'(lo_status), 2);
        idle();
        chk("R6 nothing started while held", int'(conv_start), 0);
        step(0, 1, 1, 2'b00);
        chk("R6 lo continues at next entry", int'(cmd_idx), 10);
        idle();
        step(1, 0, 1, 2'b00);
        chk("R6 hi continues at entry 2", int'(cmd_idx), 2);
        chk("R4 lo set aside again", int'(lo_status), 4);
        step(0, 1, 0, 2'b00);
        chk("R8 lo overrun while aside", int'(ovr_flag[1]), 1);

        wait_hi(5);
        chk("R7 hi finished", int'(hi_status), 5);
        chk("R7 hi pulse", int'(cmpl_pulse), 1);
        chk("R5 lo restarts at subqueue start", int'(cmd_idx), 10);
        idle();
        chk("R7 pulse lasts one cycle", int'(cmpl_pulse), 0);
        step(0, 1, 0, 2'b10);
        chk("R8 set wins over clear", int'(ovr_flag[1]), 1);
        step(0, 0, 0, 2'b10);
        chk("R8 cleared", int'(ovr_flag[1]), 0);

        wait_lo(5);
        step(1, 1, 0, 2'b00);
        chk("R3 joint trigger hi runs", int'(hi_status), 1);
        chk("R3 joint trigger lo pending", int'(lo_status), 3);
        chk("R2 hi restarts at base", int'(cmd_idx), 0);
        wait_hi(2);
        chk("R3 pending lo runs on hold", int'(lo_status), 1);
        chk("R7 lo restarts at base", int'(cmd_idx), LO_BASE);

        // finishing low entry meets a high trigger in the same cycle
        do_reset();
        step(0, 1, 0, 2'b00);
        wait_lo(2);
        step(0, 1, 0, 2'b00);
        for (int i = 0; i < 60 && !(cnt == 1 && int'(cmd_idx) == 12); i++) idle();
        step(1, 0, 0, 2'b00);
        chk("R9 lo finished not aside", int'(lo_status), 5);
        chk("R9 lo pulse", int'(cmpl_pulse), 2);
        chk("R9 no abort", int'(conv_abort), 0);
        chk("R9 hi started", int'(cmd_idx), 0);

        // random phase
        do_reset();
        tb_hold = 16'($urandom);
        tb_last = 16'($urandom & $urandom) | 16'h8080;
        for (int i = 0; i < 6000; i++) begin
            step(($urandom % 14) == 0, ($urandom % 9) == 0, 1'($urandom),
                 (($urandom % 25) == 0) ? 2'($urandom) : 2'b00);
        end

        summary();
        $finish;
    end

endmodule